// File: doc/BRIEF.md
# Lane Address Memory Coalescer

The coalescer accepts one memory request on behalf of a group of sixteen lanes. Every lane offers a byte address for a 32-bit word, and an activity mask says which lanes are part of the request. The block turns the request into the fewest aligned memory transactions that the selected rule allows. It hands these transactions out one at a time over a valid/ready port. Each transaction is a base address and a length of 32, 64 or 128 bytes.

Two rules are available. The relaxed rule groups the active lanes by aligned 128-byte segment. Each segment is served by the smallest aligned piece that still covers every lane in it. The strict rule merges the request into one block transfer only when each active lane sits exactly at its own word slot inside a single aligned block. In every other case the strict rule issues one 32-byte transfer per active lane. A completion pulse closes every request. A misaligned active address turns the request into an error completion, and no transfers are issued for it.

Top module: `lane_coalescer`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `tx_valid` and `done` are 0.
- R2: In relaxed mode (`req_strict`=0), each aligned 128-byte segment that holds at least one active lane gets exactly one transaction. Its length is 32 if all of that segment's lanes share address bits [6:5], 64 if they share only bit [6], and 128 otherwise. Its base is aligned to its length.
- R3: In relaxed mode, a request whose lanes straddle a 128-byte boundary gets one transaction per touched segment. For example, sixteen consecutive words starting at byte 68 of a segment give a 64-byte transaction at segment offset 64, followed by a 32-byte transaction at the next segment's base.
- R4: In strict mode (`req_strict`=1), if every active lane i has address bits [5:2] equal to i and all active lanes share bits [31:6], exactly one 64-byte transaction is issued at that 64-byte block base.
- R5: In strict mode, when R4 does not apply, each active lane gets one 32-byte transaction whose base is its address with bits [4:0] cleared. Lanes in the same 32-byte block still get one transaction each.
- R6: Lanes whose mask bit is 0 have no effect on the transactions issued or on the error result, whatever their address.
- R7: A request with an all-zero mask issues no transaction, and `done` is 1 in the cycle after the request is accepted.
- R8: If any active lane has a nonzero address bits [1:0], no transaction is issued, and `done` and `err` are both 1 in the cycle after acceptance. Otherwise `err` stays 0.
- R9: The transactions of one request come out in non-decreasing base-address order.
- R10: A request is accepted on a cycle with `req_valid` and `req_ready` both 1, and `req_ready` stays 0 until the completion. A transaction holds its base and length while `tx_ready` is 0. `done` is 1 for exactly one cycle, the cycle after the last transaction is accepted, and is never 1 together with `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | LANES*AW | Byte address of lane i in bits [i*AW +: AW] |
| req_mask | input | LANES | Lane i takes part when bit i is 1 |
| req_strict | input | 1 | 1 selects the strict rule, 0 the relaxed rule |
| tx_valid | output | 1 | A transaction is offered |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_base | output | AW | Aligned base byte address of the transaction |
| tx_bytes | output | 8 | Transaction length in bytes: 32, 64 or 128 |
| done | output | 1 | One-cycle completion of the current request |
| err | output | 1 | With done: the request had a misaligned active address |

## Verification
The bench builds the block with its default values, sixteen lanes and 32-bit addresses. With these values the strict word-slot test covers a full 64-byte block. Random bases across the whole address range reach segments near the top of the space, and every shift between the 32-, 64- and 128-byte grains lines up with a real segment boundary. Random back-pressure on `tx_ready` and a mix of strides, rotations, partial masks and stray misalignments on inactive lanes reach both fallback paths, the straddling case and the error path under each rule.

// File: rtl/lane_coalescer.sv
module lane_coalescer #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_mask,
  input  logic                req_strict,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [AW-1:0]       tx_base,
  output logic [7:0]          tx_bytes,
  output logic                done,
  output logic                err
);
  localparam int LW = $clog2(LANES);
  localparam int BB = LW + 2;
  localparam logic [7:0] BLK_BYTES = 8'(LANES * 4);

  logic             busy;
  logic             strict_q;
  logic [LANES-1:0] mask_q, rem_q;
  logic [AW-1:0]    addr_q [LANES];

  logic [LW-1:0]    sel;
  logic [AW-1:0]    ref_a;
  logic             bad, coal, same32, same64;
  logic [LANES-1:0] grp, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      strict_q <= 1'b0;
      mask_q   <= '0;
      rem_q    <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy     <= 1'b1;
        strict_q <= req_strict;
        mask_q   <= req_mask;
        rem_q    <= req_mask;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else if (tx_ready) begin
      rem_q <= rem_q & ~clr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk)
      if (!busy && req_valid) addr_q[g] <= req_addr[g*AW +: AW];
  end

  always_comb begin
    logic [AW-1:0] key, best;
    logic          found;
    sel   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      key = strict_q ? (addr_q[i] >> 5) : (addr_q[i] >> 7);
      if (rem_q[i] && (!found || key < best)) begin
        best  = key;
        sel   = LW'(i);
        found = 1'b1;
      end
    end
  end

  assign ref_a = addr_q[sel];

  always_comb begin
    bad    = 1'b0;
    coal   = 1'b1;
    same32 = 1'b1;
    same64 = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      grp[i] = rem_q[i] && (addr_q[i][AW-1:7] == ref_a[AW-1:7]);
      if (mask_q[i] && addr_q[i][1:0] != 2'b00) bad = 1'b1;
      if (mask_q[i] && (addr_q[i][BB-1:2] != LW'(i) ||
                        addr_q[i][AW-1:BB] != ref_a[AW-1:BB])) coal = 1'b0;
      if (grp[i] && addr_q[i][6:5] != ref_a[6:5]) same32 = 1'b0;
      if (grp[i] && addr_q[i][6]   != ref_a[6])   same64 = 1'b0;
    end
  end

  always_comb begin
    clr = '0;
    if (!strict_q)  clr = grp;
    else if (coal)  clr = mask_q;
    else            clr[sel] = 1'b1;
  end

  always_comb begin
    if (strict_q && coal) begin
      tx_bytes = BLK_BYTES;
      tx_base  = {ref_a[AW-1:BB], BB'(0)};
    end else if (strict_q || same32) begin
      tx_bytes = 8'd32;
      tx_base  = {ref_a[AW-1:5], 5'd0};
    end else if (same64) begin
      tx_bytes = 8'd64;
      tx_base  = {ref_a[AW-1:6], 6'd0};
    end else begin
      tx_bytes = 8'd128;
      tx_base  = {ref_a[AW-1:7], 7'd0};
    end
  end

  assign req_ready = !busy;
  assign tx_valid  = busy && !bad && (rem_q != '0);
  assign done      = busy && (bad || rem_q == '0);
  assign err       = busy && bad;

endmodule

// File: rtl/lane_coalescer_chk.sv
module lane_coalescer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [AW-1:0] tx_base,
  input logic [7:0]    tx_bytes,
  input logic          done,
  input logic          err
);
  logic          have_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (req_valid && req_ready) begin
      have_q <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      have_q <= 1'b1;
      last_q <= tx_base;
    end
  end

  a_r2_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_bytes == 8'd32 || tx_bytes == 8'd64 || tx_bytes == 8'd128));

  a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_base & AW'(tx_bytes - 8'd1)) == '0));

  a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && have_q) |-> tx_base >= last_q);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_bytes)));

  a_r10_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && tx_valid));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || done) |-> !req_ready);

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !tx_valid));
endmodule

bind lane_coalescer lane_coalescer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base),
  .tx_bytes(tx_bytes), .done(done), .err(err)
);

// File: tb/tb_lane_coalescer.sv
module tb_lane_coalescer;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [511:0]  req_addr = '0;
  logic [15:0]   req_mask = '0;
  logic          req_strict = 1'b0;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic [31:0]   tx_base;
  logic [7:0]    tx_bytes;
  logic          done, err;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] la [16];
  logic [31:0] exp_base [16];
  logic [7:0]  exp_bytes [16];
  int          exp_n;
  bit          exp_err;

  always #10 clk = ~clk;

  lane_coalescer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_strict(req_strict),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base),
    .tx_bytes(tx_bytes), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic sort_expect();
    for (int a = 0; a < exp_n; a++)
      for (int b = 0; b + 1 < exp_n - a; b++)
        if (exp_base[b] > exp_base[b+1]) begin
          logic [31:0] tb_ = exp_base[b];
          logic [7:0]  ts_ = exp_bytes[b];
          exp_base[b] = exp_base[b+1]; exp_bytes[b] = exp_bytes[b+1];
          exp_base[b+1] = tb_;         exp_bytes[b+1] = ts_;
        end
  endtask

  task automatic build_expect(input logic [15:0] m, input bit s);
    int first = -1;
    bit ok = 1;
    exp_n = 0;
    exp_err = 0;
    for (int i = 0; i < 16; i++)
      if (m[i] && la[i][1:0] != 2'b00) exp_err = 1;
    if (exp_err || m == 0) return;
    if (s) begin
      for (int i = 0; i < 16; i++)
        if (m[i]) begin
          if (first < 0) first = i;
          if (la[i][5:2] != 4'(i) || la[i][31:6] != la[first][31:6]) ok = 0;
        end
      if (ok) begin
        exp_base[0] = la[first] & 32'hFFFF_FFC0; exp_bytes[0] = 8'd64; exp_n = 1;
      end else begin
        for (int i = 0; i < 16; i++)
          if (m[i]) begin
            exp_base[exp_n] = la[i] & 32'hFFFF_FFE0; exp_bytes[exp_n] = 8'd32; exp_n++;
          end
        sort_expect();
      end
    end else begin
      for (int i = 0; i < 16; i++)
        if (m[i]) begin
          bit dup = 0;
          for (int j = 0; j < exp_n; j++)
            if (exp_base[j] == (la[i] & 32'hFFFF_FF80)) dup = 1;
          if (!dup) begin
            exp_base[exp_n] = la[i] & 32'hFFFF_FF80; exp_bytes[exp_n] = 8'd128; exp_n++;
          end
        end
      sort_expect();
      for (int j = 0; j < exp_n; j++) begin
        logic [6:0] lo = 7'h7F, hi = 7'h00;
        for (int i = 0; i < 16; i++)
          if (m[i] && (la[i] & 32'hFFFF_FF80) == exp_base[j]) begin
            if (la[i][6:0] < lo) lo = la[i][6:0];
            if (la[i][6:0] > hi) hi = la[i][6:0];
          end
        if (lo[6:5] == hi[6:5]) begin
          exp_base[j] = exp_base[j] + {25'd0, lo[6:5], 5'd0}; exp_bytes[j] = 8'd32;
        end else if (lo[6] == hi[6]) begin
          exp_base[j] = exp_base[j] + {25'd0, lo[6], 6'd0}; exp_bytes[j] = 8'd64;
        end
      end
    end
  endtask

  task automatic run_req(input logic [15:0] m, input bit s, input string tag);
    int idx = 0;
    bit pend, fin = 0;
    build_expect(m, s);
    @(negedge clk);
    for (int i = 0; i < 16; i++) req_addr[i*32 +: 32] = la[i];
    req_mask = m; req_strict = s; req_valid = 1'b1;
    check(req_ready == 1'b1, "R10", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    pend = (exp_n == 0);
    while (!fin) begin
      if (done) begin
        check(idx == exp_n, exp_err ? "R8" : (exp_n == 0 ? "R7" : tag), 32'(idx), 32'(exp_n));
        check(err == exp_err, "R8", 32'(err), 32'(exp_err));
        check(pend, "R10", 32'(done), 32'(pend));
        tx_ready = 1'b0;
        fin = 1;
      end else begin
        if (pend) begin
          check(0, "R10", 32'(done), 32'd1);
          pend = 0;
        end
        if (tx_valid) begin
          tx_ready = ($urandom % 4) != 0;
          if (tx_ready) begin
            if (idx < exp_n) begin
              check(tx_base == exp_base[idx], tag, tx_base, exp_base[idx]);
              check(tx_bytes == exp_bytes[idx], tag, 32'(tx_bytes), 32'(exp_bytes[idx]));
            end else begin
              check(0, tag, tx_base, 32'hFFFF_FFFF);
            end
            idx++;
            if (idx == exp_n) pend = 1;
          end
        end else begin
          tx_ready = 1'b0;
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic fill_stride(input logic [31:0] base, input int stride);
    for (int i = 0; i < 16; i++) la[i] = base + 32'(stride * 4 * i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    check(req_ready && !tx_valid && !done, "R1", {req_ready, tx_valid, done}, 3'b100);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !tx_valid && !done, "R1", {req_ready, tx_valid, done}, 3'b100);

    fill_stride(32'h0000_1000, 1); run_req(16'hFFFF, 0, "R2");
    fill_stride(32'h0000_1000, 1); run_req(16'hFFFF, 1, "R4");
    fill_stride(32'h0000_2044, 1); run_req(16'hFFFF, 0, "R3");
    fill_stride(32'h0000_2044, 1); run_req(16'hFFFF, 1, "R5");
    fill_stride(32'h0000_3000, 2); run_req(16'hFFFF, 0, "R2");
    fill_stride(32'h0000_4000, 32); run_req(16'hFFFF, 0, "R2");
    fill_stride(32'h0000_4000, 32); run_req(16'hFFFF, 1, "R5");
    fill_stride(32'h0000_5000, 1); la[3] = 32'h7777_0003; la[9] = 32'h0000_0100;
    run_req(16'hFDF7, 0, "R6");
    fill_stride(32'h0000_5000, 1); la[3] = 32'h7777_0001;
    run_req(16'hF0F0, 1, "R6");
    fill_stride(32'h0000_6000, 1); run_req(16'h0000, 0, "R7");
    fill_stride(32'h0000_6000, 1); la[5] = 32'h0000_6016; run_req(16'hFFFF, 0, "R8");
    fill_stride(32'h0000_6000, 1); la[5] = 32'h0000_6016; run_req(16'hFFFF, 1, "R8");
    fill_stride(32'hFFFF_FF80, 1); run_req(16'hFFFF, 0, "R9");
    for (int i = 0; i < 16; i++) la[i] = 32'h0000_7000 + 32'(4 * (15 - i));
    run_req(16'hFFFF, 1, "R9");

    for (int t = 0; t < 400; t++) begin
      logic [31:0] base = $urandom & 32'hFFFF_FFC0;
      int kind = $urandom % 6;
      logic [15:0] m = ($urandom % 4 != 0) ? 16'hFFFF : 16'($urandom);
      bit s = $urandom % 2;
      int rot = $urandom % 16;
      case (kind)
        0: fill_stride(base, 1);
        1: fill_stride(base + (($urandom % 32) * 4), 1);
        2: fill_stride(base, 2);
        3: fill_stride(base, 32);
        4: for (int i = 0; i < 16; i++) la[i] = base + (($urandom % 128) * 4);
        default: for (int i = 0; i < 16; i++) la[i] = base + 32'(4 * ((i + rot) % 16));
      endcase
      if ($urandom % 16 == 0) la[$urandom % 16][1:0] = 2'($urandom % 3 + 1);
      run_req(m, s, s ? "R5" : "R2");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule